// File: doc/BRIEF.md
# Parallel-Bus ADC Control Sequencer

This block is the digital control for an 8-bit two-step converter that sits on a microprocessor-style parallel bus. It takes active-low chip-select, read and write strobes, a protocol select, an active-low power-down input and a 3-bit channel index. It drives an 8-bit data value with a separate output-enable (standing for a three-state bus), an active-low end-of-conversion flag and a drive-low enable for an open-drain ready line. All inputs pass through a two-stage synchronizer into one system clock. The converter itself is a digital stub. It captures the selected channel's code when the conversion starts, gives the upper nibble at once and signals the lower nibble after `CONV_CYC` clock cycles.

With the protocol select low (read protocol), holding chip-select and read low starts a conversion. The ready line is pulled low until the result is ready, and the result then appears while read stays low. With the protocol select high (write-read protocol), a falling write edge samples the input. The rising write edge latches the upper nibble and starts the lower-nibble delay. A falling read edge during that delay finishes the conversion at once. Tying write and read together gives pipelined use: each low pulse shows the previous result and starts the next conversion.

The state machine has eight states. `ST_OFF` (powered down) goes to `ST_WAKE` when power-down is released. `ST_WAKE` goes to `ST_IDLE` after `PWRUP_CYC` cycles. From `ST_IDLE`, a read-protocol start goes to `ST_RCONV`, which goes to `ST_RDONE` when the delay ends. `ST_RDONE` returns to `ST_IDLE` on a rising chip-select or read. A write-protocol start goes from `ST_IDLE` to `ST_WHOLD`. A rising write goes from `ST_WHOLD` to `ST_WLOW`. `ST_WLOW` goes to `ST_WDONE` either when the delay ends or on a read falling edge while chip-select is low. `ST_WDONE` goes to `ST_WHOLD` on a new falling write with chip-select low, and to `ST_IDLE` on a rising chip-select or read. A low power-down input forces `ST_OFF` from any state.

Top module: `adc_bus_seq`

## Requirements
- R1: After reset, `int_n` is 1, `d_oe` is 0 and `rdy_pull` is 0.
- R2: With `mode`=0, holding `cs_n` and `rd_n` low starts a conversion. The result is placed on `d_out` with `d_oe`=1 once the internal delay has elapsed, while `rd_n` is still low.
- R3: With `mode`=0, `rdy_pull` is 1 while `cs_n` is low and no result is waiting. It drops to 0 in the same cycle that the result becomes ready.
- R4: `int_n` goes to 0 when a result becomes ready and returns to 1 after a rising edge of `cs_n` or `rd_n`.
- R5: With `mode`=1, a falling `wr_n` edge while `cs_n` is low samples the channel. The rising `wr_n` edge latches bits [7:4] and starts the lower-nibble delay. `int_n` falls when bits [3:0] are latched. A change on the input after the falling edge does not alter the result.
- R6: With `mode`=1, `d_oe` is 1 only while both `cs_n` and `rd_n` are low.
- R7: With `mode`=1, a falling `rd_n` edge while `cs_n` is low, during the lower-nibble delay, completes the conversion at once and drives `int_n` low well before the delay would have ended.
- R8: With `mode`=1 and `wr_n` tied to `rd_n`, each low pulse shows the previous conversion's result on `d_out` and starts a new conversion.
- R9: `addr` is a binary channel index, 0 to 7 selecting byte `ain_flat[8*addr +: 8]`. Index 7 always converts to 8'hFF, whatever its input byte holds.
- R10: A start request that arrives while `pwrdn_n` is low, or within `PWRUP_CYC` cycles after it rises, is ignored and produces no `int_n` fall.
- R11: While `pwrdn_n` is low, `int_n` is 1, `d_oe` is 0 and `rdy_pull` is 0, even if a result was being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (write-read protocol) |
| mode | input | 1 | Protocol select: 0 read, 1 write-read |
| pwrdn_n | input | 1 | Power-down request, active low |
| addr | input | 3 | Channel index |
| ain_flat | input | 64 | Stub input codes, one byte per channel |
| d_out | output | 8 | Data bus value |
| d_oe | output | 1 | Data bus output enable |
| int_n | output | 1 | End-of-conversion flag, active low |
| rdy_pull | output | 1 | Drive-low enable for the open-drain ready line |

## Verification
On every cycle, the embedded properties check these points:
- a low power-down input forces the off state and clears the wake-up counter;
- nothing is sampled or started while asleep or waking;
- the ready line releases and the flag falls together when a read-protocol conversion ends;
- the flag rises after a chip-select or read rising edge;
- the upper nibble equals the stub's value after a write rising edge;
- an early read finishes the lower-nibble phase;
- the last channel always converts to all ones;
- the delay counter's done pulse lasts one cycle.

Some behaviours only the bench's scenarios can show:
- that data is sampled at the write falling edge and not later;
- that a pipelined pulse returns the prior result;
- the channel mapping across addresses;
- that a start request during wake-up leaves no trace once the block is awake.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_IDLE,
        ST_RCONV,
        ST_RDONE,
        ST_WHOLD,
        ST_WLOW,
        ST_WDONE
    } seq_state_t;

endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
    parameter int            W       = 8,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_pwr_ctl.sv
module adc_pwr_ctl #(
    parameter int PWRUP_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    output logic ready
);

    localparam int PW = $clog2(PWRUP_CYC + 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!pwr_on) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (cnt == PW'(PWRUP_CYC)) begin
            ready <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SLEEP_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !ready); // R10

endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
    parameter int NCH      = 8,
    parameter int DW       = 8,
    parameter int CONV_CYC = 12,
    parameter bit TIE_LAST = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     samp_en,
    input  logic [$clog2(NCH)-1:0]   chan,
    input  logic [NCH*DW-1:0]        ain_flat,
    input  logic                     start,
    input  logic                     abort,
    output logic [DW/2-1:0]          code_hi,
    output logic [DW/2-1:0]          code_lo,
    output logic                     done
);

    localparam int CHW = $clog2(NCH);
    localparam int NIB = DW / 2;
    localparam int CW  = $clog2(CONV_CYC + 1);

    logic [DW-1:0] held;
    logic [DW-1:0] picked;
    logic [CW-1:0] cnt;

    generate
        if (TIE_LAST) begin : g_tied
            assign picked = (chan == CHW'(NCH - 1)) ? {DW{1'b1}} : ain_flat[chan*DW +: DW];
        end else begin : g_free
            assign picked = ain_flat[chan*DW +: DW];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (samp_en) begin
            held <= picked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (abort) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CONV_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done    = (cnt == CW'(1));
    assign code_hi = held[DW-1 -: NIB];
    assign code_lo = held[NIB-1:0];

    AST_LAST_CHAN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && TIE_LAST && chan == CHW'(NCH - 1)) |=> (held == {DW{1'b1}})); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done); // R2

endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int DW        = 8,
    parameter int CONV_CYC  = 12,
    parameter int PWRUP_CYC = 20,
    parameter int SYNC_STG  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic                    mode,
    input  logic                    pwrdn_n,
    input  logic [$clog2(NCH)-1:0]  addr,
    input  logic [NCH*DW-1:0]       ain_flat,
    output logic [DW-1:0]           d_out,
    output logic                    d_oe,
    output logic                    int_n,
    output logic                    rdy_pull
);

    localparam int CHW = $clog2(NCH);
    localparam int NIB = DW / 2;
    localparam int SW  = 5 + CHW;
    localparam logic [SW-1:0] SYNC_RST = {3'b111, 1'b0, 1'b0, {CHW{1'b0}}};

    // synchronized inputs
    logic [SW-1:0]  raw_in, syn_in;
    logic           s_cs_n, s_rd_n, s_wr_n, pwr_on, s_mode;
    logic [CHW-1:0] s_addr;
    logic           p_cs_n, p_rd_n, p_wr_n;
    logic           cs_act, rd_act, cs_rise, rd_rise, rd_fall, wr_rise, wr_fall;

    assign raw_in = {cs_n, rd_n, wr_n, pwrdn_n, mode, addr};

    adc_in_sync #(.W(SW), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {s_cs_n, s_rd_n, s_wr_n, pwr_on, s_mode, s_addr} = syn_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_cs_n <= 1'b1;
            p_rd_n <= 1'b1;
            p_wr_n <= 1'b1;
        end else begin
            p_cs_n <= s_cs_n;
            p_rd_n <= s_rd_n;
            p_wr_n <= s_wr_n;
        end
    end

    assign cs_act  = !s_cs_n;
    assign rd_act  = !s_rd_n;
    assign cs_rise = s_cs_n && !p_cs_n;
    assign rd_rise = s_rd_n && !p_rd_n;
    assign rd_fall = !s_rd_n && p_rd_n;
    assign wr_rise = s_wr_n && !p_wr_n;
    assign wr_fall = !s_wr_n && p_wr_n;

    // power-up timer
    logic awake;

    adc_pwr_ctl #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_on (pwr_on),
        .ready  (awake)
    );

    // converter stub
    logic           samp_en, conv_start, conv_abort, conv_done;
    logic [NIB-1:0] code_hi, code_lo;

    adc_conv_stub #(.NCH(NCH), .DW(DW), .CONV_CYC(CONV_CYC), .TIE_LAST(1'b1)) u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_en  (samp_en),
        .chan     (s_addr),
        .ain_flat (ain_flat),
        .start    (conv_start),
        .abort    (conv_abort),
        .code_hi  (code_hi),
        .code_lo  (code_lo),
        .done     (conv_done)
    );

    // state machine
    seq_state_t state, nxt;
    logic       hi_latch, lo_latch, full_latch;
    logic [DW-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt        = state;
        samp_en    = 1'b0;
        conv_start = 1'b0;
        conv_abort = 1'b0;
        hi_latch   = 1'b0;
        lo_latch   = 1'b0;
        full_latch = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (pwr_on) nxt = ST_WAKE;
            end
            ST_WAKE: begin
                if (awake) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (!s_mode && cs_act && rd_act) begin
                    nxt        = ST_RCONV;
                    samp_en    = 1'b1;
                    conv_start = 1'b1;
                end else if (s_mode && cs_act && wr_fall) begin
                    nxt     = ST_WHOLD;
                    samp_en = 1'b1;
                end
            end
            ST_RCONV: begin
                if (conv_done) begin
                    nxt        = ST_RDONE;
                    full_latch = 1'b1;
                end
            end
            ST_RDONE: begin
                if (cs_rise || rd_rise) nxt = ST_IDLE;
            end
            ST_WHOLD: begin
                if (wr_rise) begin
                    nxt        = ST_WLOW;
                    hi_latch   = 1'b1;
                    conv_start = 1'b1;
                end
            end
            ST_WLOW: begin
                if (rd_fall && cs_act) begin
                    nxt        = ST_WDONE;
                    lo_latch   = 1'b1;
                    conv_abort = 1'b1;
                end else if (conv_done) begin
                    nxt      = ST_WDONE;
                    lo_latch = 1'b1;
                end
            end
            ST_WDONE: begin
                if (cs_act && wr_fall) begin
                    nxt     = ST_WHOLD;
                    samp_en = 1'b1;
                end else if (cs_rise || rd_rise) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_OFF;
        endcase
        if (!pwr_on) begin
            nxt        = ST_OFF;
            samp_en    = 1'b0;
            conv_start = 1'b0;
            conv_abort = 1'b1;
            hi_latch   = 1'b0;
            lo_latch   = 1'b0;
            full_latch = 1'b0;
        end
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            if (full_latch) res_q <= {code_hi, code_lo};
            if (hi_latch)   res_q[DW-1 -: NIB] <= code_hi;
            if (lo_latch)   res_q[NIB-1:0] <= code_lo;
        end
    end

    // outputs
    always_comb begin
        d_out    = res_q;
        int_n    = 1'b1;
        d_oe     = 1'b0;
        rdy_pull = 1'b0;
        unique case (state)
            ST_OFF, ST_WAKE: ;
            ST_IDLE, ST_RCONV: begin
                rdy_pull = !s_mode && cs_act;
                d_oe     = s_mode && cs_act && rd_act;
            end
            ST_RDONE: begin
                int_n = 1'b0;
                d_oe  = cs_act && rd_act;
            end
            ST_WHOLD, ST_WLOW: begin
                d_oe = s_mode && cs_act && rd_act;
            end
            ST_WDONE: begin
                int_n = 1'b0;
                d_oe  = s_mode && cs_act && rd_act;
            end
            default: ;
        endcase
    end

    AST_SLEEP_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (state == ST_OFF)); // R11

    AST_NO_START_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF || state == ST_WAKE) |-> (!samp_en && !conv_start)); // R10

    AST_READY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RCONV && conv_done && pwr_on) |=> (!int_n && !rdy_pull)); // R3

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDONE && pwr_on && (cs_rise || rd_rise)) |=> int_n); // R4

    AST_UPPER_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        hi_latch |=> (res_q[DW-1 -: NIB] == $past(code_hi))); // R5

    AST_EARLY_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WLOW && pwr_on && cs_act && rd_fall) |=> !int_n); // R7

endmodule

// File: tb/sim_adc_bus_seq.sv
module sim_adc_bus_seq;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, rd_n, wr_n, mode, pwrdn_n;
    logic [2:0]  addr;
    logic [63:0] ain_flat;
    logic [7:0]  d_out;
    logic        d_oe, int_n, rdy_pull;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    adc_bus_seq #(.NCH(8), .DW(8), .CONV_CYC(12), .PWRUP_CYC(20), .SYNC_STG(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .mode(mode), .pwrdn_n(pwrdn_n), .addr(addr), .ain_flat(ain_flat),
        .d_out(d_out), .d_oe(d_oe), .int_n(int_n), .rdy_pull(rdy_pull)
    );

    // {addr, expected code}; index 7 carries 8'h87 at its input but reads all ones
    localparam logic [10:0] VEC [6] = '{
        {3'd0, 8'h1E}, {3'd3, 8'h4B}, {3'd7, 8'hFF},
        {3'd6, 8'h78}, {3'd1, 8'h2D}, {3'd5, 8'h69}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        mode = 1'b0; pwrdn_n = 1'b1; addr = 3'd0;
        ain_flat = {8'h87, 8'h78, 8'h69, 8'h5A, 8'h4B, 8'h3C, 8'h2D, 8'h1E};
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        chk("R1 int_n", int_n, 1);
        chk("R1 d_oe", d_oe, 0);
        chk("R1 rdy_pull", rdy_pull, 0);
        cyc(30);

        // read protocol table
        for (int i = 0; i < 6; i++) begin
            addr = VEC[i][10:8];
            cyc(4);
            cs_n = 1'b0;
            cyc(4);
            chk("R3 ready held low", rdy_pull, 1);
            rd_n = 1'b0;
            cyc(4);
            chk("R2 busy no data", d_oe, 0);
            chk("R4 flag idle", int_n, 1);
            cyc(20);
            chk("R2 data enable", d_oe, 1);
            chk("R2 R9 data value", d_out, VEC[i][7:0]);
            chk("R4 flag low", int_n, 0);
            chk("R3 ready released", rdy_pull, 0);
            if (i % 2 == 0) begin
                rd_n = 1'b1;
                cyc(4);
                chk("R4 flag after rd rise", int_n, 1);
                cs_n = 1'b1;
            end else begin
                cs_n = 1'b1;
                cyc(4);
                chk("R4 flag after cs rise", int_n, 1);
                rd_n = 1'b1;
            end
            cyc(4);
        end

        // write-read with internal delay
        mode = 1'b1; addr = 3'd2;
        cyc(4);
        cs_n = 1'b0;
        cyc(2);
        wr_n = 1'b0;
        cyc(4);
        ain_flat[2*8 +: 8] = 8'hA5;
        wr_n = 1'b1;
        cyc(4);
        chk("R5 lower phase pending", int_n, 1);
        cyc(20);
        chk("R5 flag after delay", int_n, 0);
        chk("R6 no drive without rd", d_oe, 0);
        rd_n = 1'b0;
        cyc(4);
        chk("R6 drive with cs and rd", d_oe, 1);
        chk("R5 sampled at falling wr", d_out, 8'h3C);
        cs_n = 1'b1;
        cyc(4);
        chk("R6 no drive without cs", d_oe, 0);
        chk("R4 flag after cs rise", int_n, 1);
        rd_n = 1'b1;
        ain_flat[2*8 +: 8] = 8'h3C;
        cyc(4);

        // write-read, read before the delay ends
        addr = 3'd4;
        cyc(4);
        cs_n = 1'b0;
        cyc(2);
        wr_n = 1'b0;
        cyc(4);
        wr_n = 1'b1;
        cyc(3);
        rd_n = 1'b0;
        cyc(4);
        chk("R7 early flag", int_n, 0);
        chk("R7 early data", d_out, 8'h5A);
        chk("R7 early enable", d_oe, 1);
        rd_n = 1'b1;
        cyc(4);
        chk("R7 R4 flag cleared", int_n, 1);
        cyc(4);

        // pipelined: wr and rd together
        addr = 3'd5;
        cyc(4);
        wr_n = 1'b0; rd_n = 1'b0;
        cyc(4);
        chk("R8 enable in pulse", d_oe, 1);
        chk("R8 previous result", d_out, 8'h5A);
        wr_n = 1'b1; rd_n = 1'b1;
        cyc(20);
        chk("R8 flag after delay", int_n, 0);
        addr = 3'd1;
        cyc(4);
        wr_n = 1'b0; rd_n = 1'b0;
        cyc(4);
        chk("R8 previous result 2", d_out, 8'h69);
        wr_n = 1'b1; rd_n = 1'b1;
        cyc(20);
        wr_n = 1'b0; rd_n = 1'b0;
        cyc(4);
        chk("R8 previous result 3", d_out, 8'h2D);
        wr_n = 1'b1; rd_n = 1'b1;
        cyc(20);
        cs_n = 1'b1;
        cyc(4);

        // power-down
        mode = 1'b0; addr = 3'd6;
        cyc(4);
        cs_n = 1'b0; rd_n = 1'b0;
        cyc(24);
        chk("R2 before sleep", d_oe, 1);
        pwrdn_n = 1'b0;
        cyc(4);
        chk("R11 enable off", d_oe, 0);
        chk("R11 flag high", int_n, 1);
        chk("R11 ready off", rdy_pull, 0);
        cs_n = 1'b1; rd_n = 1'b1;
        cyc(4);
        cs_n = 1'b0; rd_n = 1'b0;
        cyc(24);
        chk("R10 no flag asleep", int_n, 1);
        chk("R10 no data asleep", d_oe, 0);
        cs_n = 1'b1; rd_n = 1'b1;
        cyc(4);
        pwrdn_n = 1'b1;
        cs_n = 1'b0; rd_n = 1'b0;
        cyc(6);
        cs_n = 1'b1; rd_n = 1'b1;
        cyc(40);
        chk("R10 no flag from wake start", int_n, 1);
        addr = 3'd3;
        cyc(4);
        cs_n = 1'b0; rd_n = 1'b0;
        cyc(24);
        chk("R10 awake conversion", d_out, 8'h4B);
        chk("R10 awake flag", int_n, 0);
        cs_n = 1'b1; rd_n = 1'b1;
        cyc(4);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule